// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This block keeps a 32-bit running count of seconds. A prescaler divides the input clock down to one update tick per second. Software reaches the block through a small register bus that completes each access in one cycle. The bus lets software program a match value, a load value and a control word, and read the count, the status bits and a fixed version word. On the tick where the count reaches the match value, the block latches a pending alarm. The alarm drives an interrupt line through separate enable and mask bits.

A new count written by software does not take effect at once. It is held as a pending load and takes the counter's place at the next update tick, so the count never changes between ticks. To acknowledge the alarm, software reads a dedicated register; no write is needed. An optional wrap mode makes the counter restart from the load value on the tick after a match, which turns the block into a periodic alarm.

Top module: `sec_alarm_timer`

## Requirements
- R1: After reset, the count, match, load, control, masked status and raw status registers all read 0, `alarm_irq` is low, and no load is pending.
- R2: Byte offsets, each word-aligned: 0x00 count (read-only), 0x04 match, 0x08 load, 0x0C control, 0x10 masked status, 0x14 raw status, 0x18 acknowledge, 0x1C version. The version register returns the `VERSION` parameter. Writes to 0x00, 0x10, 0x14, 0x18 and 0x1C change nothing. Control bits: 0 interrupt enable, 1 interrupt mask, 2 count enable, 3 wrap enable. Control bits 31:4 read as 0.
- R3: A write to the load register leaves the count unchanged until the next update tick. At that tick the count becomes the load value that was held in the cycle of the tick.
- R4: While count enable is set, an update tick occurs once every `PRESCALE` clock cycles. The first tick comes `PRESCALE` cycles after the enable takes effect. On a tick with no pending load and no wrap reload, the count advances by 1 and wraps from 0xFFFFFFFF to 0.
- R5: While count enable is clear, the count holds and the prescaler returns to its start.
- R6: On a tick whose new count equals the match register, raw status bit 0 becomes 1.
- R7: Raw status stays 1 until an acknowledge read. When a new match and an acknowledge read fall in the same cycle, the match wins.
- R8: Masked status bit 0 and `alarm_irq` both equal raw status AND enable AND NOT mask.
- R9: A read of 0x18 returns 0 and clears raw status at the end of that cycle.
- R10: If wrap enable is set on a matching tick, the next tick loads the count from the load register instead of incrementing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe; also triggers the acknowledge side effect |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
The hardest condition to reach is a wrap reload that collides with other events. Such a tick can coincide with a fresh load write, a change to the match register, or an acknowledge read, and each of these lands on a single cycle of a slow tick. The bench uses a short prescale and sets match values only a few counts ahead of the model's current count, so matches and wrap reloads happen often. It then mixes in random writes to load, match and control and random acknowledge reads on every cycle, so these events fall on tick cycles many times over the run. A cycle-level reference model in the bench follows every access.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam logic [2:0] IDX_COUNT = 3'd0;
  localparam logic [2:0] IDX_MATCH = 3'd1;
  localparam logic [2:0] IDX_LOAD  = 3'd2;
  localparam logic [2:0] IDX_CTRL  = 3'd3;
  localparam logic [2:0] IDX_MSTAT = 3'd4;
  localparam logic [2:0] IDX_RSTAT = 3'd5;
  localparam logic [2:0] IDX_ACK   = 3'd6;
  localparam logic [2:0] IDX_VER   = 3'd7;

  localparam int CTL_IE   = 0;
  localparam int CTL_MASK = 1;
  localparam int CTL_EN   = 2;
  localparam int CTL_WRAP = 3;
  localparam int CTL_W    = 4;

  typedef struct packed {
    logic loadWr;
    logic matchWr;
    logic cntEn;
    logic wrapEn;
  } dpStrobe_t;
endpackage

// File: rtl/sat_dpath.sv
module sat_dpath
  import sat_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PRESCALE = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] matchVal,
  output logic [DATA_W-1:0] loadVal,
  output logic              matchSet
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0]  preCnt;
  logic              tick;
  logic              loadPend;
  logic              wrapArm;
  logic [DATA_W-1:0] nextCount;

  assign tick = strobe.cntEn && (preCnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)             preCnt <= '0;
    else if (!strobe.cntEn) preCnt <= '0;
    else if (tick)          preCnt <= '0;
    else                    preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    if (loadPend || wrapArm) nextCount = loadVal;
    else                     nextCount = count + 1'b1;
  end

  assign matchSet = tick && (nextCount == matchVal);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      wrapArm  <= 1'b0;
      loadPend <= 1'b0;
      matchVal <= '0;
      loadVal  <= '0;
    end else begin
      if (tick) begin
        count   <= nextCount;
        wrapArm <= strobe.wrapEn && (nextCount == matchVal);
      end
      if (strobe.loadWr)  loadPend <= 1'b1;
      else if (tick)      loadPend <= 1'b0;
      if (strobe.loadWr)  loadVal  <= wrData;
      if (strobe.matchWr) matchVal <= wrData;
    end
  end

  // R4: count moves only on a tick
  p_step_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
  // R4: plain tick increments
  p_incr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !loadPend && !wrapArm) |=> (count == $past(count) + 1'b1));
  // R3: pending load applies at the tick
  p_load_apply_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && loadPend) |=> (count == $past(loadVal)));
  // R5: disabled counter holds and prescaler restarts
  p_hold_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.cntEn |=> ((preCnt == '0) && $stable(count)));
endmodule

// File: rtl/sat_ctrl.sv
module sat_ctrl
  import sat_pkg::*;
#(
  parameter int                DATA_W  = 32,
  parameter int                ADDR_W  = 5,
  parameter logic [DATA_W-1:0] VERSION = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] count,
  input  logic [DATA_W-1:0] matchVal,
  input  logic [DATA_W-1:0] loadVal,
  input  logic              matchSet
);
  logic [CTL_W-1:0] ctrlReg;
  logic             rawStat;
  logic             sel;
  logic [2:0]       idx;
  logic             ackRd;
  logic             maskedStat;

  assign sel   = (addr[1:0] == 2'b00) && ((addr >> 5) == '0);
  assign idx   = addr[4:2];
  assign ackRd = rdEn && sel && (idx == IDX_ACK);

  assign strobe.loadWr  = wrEn && sel && (idx == IDX_LOAD);
  assign strobe.matchWr = wrEn && sel && (idx == IDX_MATCH);
  assign strobe.cntEn   = ctrlReg[CTL_EN];
  assign strobe.wrapEn  = ctrlReg[CTL_WRAP];

  assign maskedStat = rawStat && ctrlReg[CTL_IE] && !ctrlReg[CTL_MASK];
  assign irq        = maskedStat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrlReg <= '0;
      rawStat <= 1'b0;
    end else begin
      if (wrEn && sel && (idx == IDX_CTRL)) ctrlReg <= wrData[CTL_W-1:0];
      if (matchSet)   rawStat <= 1'b1;
      else if (ackRd) rawStat <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    if (sel) begin
      case (idx)
        IDX_COUNT: rdData = count;
        IDX_MATCH: rdData = matchVal;
        IDX_LOAD:  rdData = loadVal;
        IDX_CTRL:  rdData = {{(DATA_W-CTL_W){1'b0}}, ctrlReg};
        IDX_MSTAT: rdData = {{(DATA_W-1){1'b0}}, maskedStat};
        IDX_RSTAT: rdData = {{(DATA_W-1){1'b0}}, rawStat};
        IDX_ACK:   rdData = '0;
        IDX_VER:   rdData = VERSION;
        default:   rdData = '0;
      endcase
    end
  end

  // R6: a match tick sets raw status
  p_match_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    matchSet |=> rawStat);
  // R7: raw status is sticky without acknowledge
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rawStat && !ackRd) |=> rawStat);
  // R9: acknowledge read clears unless a new match arrives
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ackRd && !matchSet) |=> !rawStat);
endmodule

// File: rtl/sec_alarm_timer.sv
module sec_alarm_timer
  import sat_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 5,
  parameter int                PRESCALE = 32768,
  parameter logic [DATA_W-1:0] VERSION  = 32'h0001_0004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              alarm_irq
);
  dpStrobe_t         strobe;
  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] matchVal;
  logic [DATA_W-1:0] loadVal;
  logic              matchSet;

  sat_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .VERSION(VERSION)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wrEn(bus_wr), .wrData(bus_wdata),
    .rdEn(bus_rd), .rdData(bus_rdata), .irq(alarm_irq), .strobe(strobe),
    .count(count), .matchVal(matchVal), .loadVal(loadVal), .matchSet(matchSet)
  );

  sat_dpath #(.DATA_W(DATA_W), .PRESCALE(PRESCALE)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrData(bus_wdata),
    .count(count), .matchVal(matchVal), .loadVal(loadVal), .matchSet(matchSet)
  );
endmodule

// File: tb/sec_alarm_timer_bench.sv
module sec_alarm_timer_bench;
  localparam int P = 4;
  localparam logic [31:0] VER = 32'hA5C3_0102;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [4:0]  addr = '0;
  logic        wr = 0;
  logic [31:0] wdata = '0;
  logic        rd = 0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [31:0] mCount, mMatch, mLoad;
  logic [3:0]  mCtrl;
  logic        mRaw, mPend, mArm;
  int          mPre;

  always #2 clk = ~clk;

  sec_alarm_timer #(.DATA_W(32), .ADDR_W(5), .PRESCALE(P), .VERSION(VER)) u_sec_alarm_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rd(rd), .bus_rdata(rdata), .alarm_irq(irq)
  );

  function automatic logic mIrq();
    return mRaw && mCtrl[0] && !mCtrl[1];
  endfunction

  function automatic logic [31:0] mRead(input logic [4:0] a);
    case (a)
      5'h00: return mCount;
      5'h04: return mMatch;
      5'h08: return mLoad;
      5'h0C: return {28'd0, mCtrl};
      5'h10: return {31'd0, mIrq()};
      5'h14: return {31'd0, mRaw};
      5'h1C: return VER;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tagFor(input logic [4:0] a);
    case (a)
      5'h00: return "R4";
      5'h10: return "R8";
      5'h14: return "R7";
      5'h18: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mCount = 0; mMatch = 0; mLoad = 0; mCtrl = 0;
    mRaw = 0; mPend = 0; mArm = 0; mPre = 0;
  endtask

  // one bus cycle; called at negedge
  task automatic op(input logic [4:0] a, input bit w, input logic [31:0] d,
                    input bit r, input string tag);
    logic        tk, hit;
    logic [31:0] nv;
    addr = a; wr = w; wdata = d; rd = r;
    #1;
    if (r) check(rdata, mRead(a), tag);
    check({31'd0, irq}, {31'd0, mIrq()}, "R8");
    tk = mCtrl[2] && (mPre == P - 1);
    hit = 0;
    nv = mCount;
    @(posedge clk);
    if (tk) begin
      nv = (mPend || mArm) ? mLoad : mCount + 1;
      hit = (nv == mMatch);
      mArm = mCtrl[3] && hit;
      mPend = 0;
      mCount = nv;
    end
    if (!mCtrl[2] || tk) mPre = 0; else mPre++;
    if (r && a == 5'h18) mRaw = 0;
    if (hit) mRaw = 1;
    if (w) begin
      if (a == 5'h04) mMatch = d;
      if (a == 5'h08) begin mLoad = d; mPend = 1; end
      if (a == 5'h0C) mCtrl = d[3:0];
    end
    @(negedge clk);
    wr = 0; rd = 0;
  endtask

  task automatic idleRead(input int n, input logic [4:0] a, input string tag);
    for (int i = 0; i < n; i++) op(a, 0, 0, 1, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    modelReset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int k = 0; k < 6; k++) op(5'(k * 4), 0, 0, 1, "R1");
    check({31'd0, irq}, 32'd0, "R1");
    // R2 version and ignored writes
    op(5'h1C, 0, 0, 1, "R2");
    op(5'h00, 1, 32'h55, 0, "R2");
    op(5'h14, 1, 32'h1, 0, "R2");
    op(5'h00, 0, 0, 1, "R2");
    op(5'h14, 0, 0, 1, "R2");
    // R4 counting
    op(5'h0C, 1, 32'h4, 0, "R2");
    idleRead(3 * P + 1, 5'h00, "R4");
    // R3 deferred load
    op(5'h08, 1, 32'd100, 0, "R3");
    idleRead(P + 2, 5'h00, "R3");
    // R5 hold while disabled
    op(5'h0C, 1, 32'h0, 0, "R5");
    idleRead(3 * P, 5'h00, "R5");
    // R6 match with irq enabled
    op(5'h04, 1, mCount + 2, 0, "R6");
    op(5'h0C, 1, 32'h5, 0, "R6");
    idleRead(3 * P, 5'h14, "R6");
    // R8 mask
    op(5'h0C, 1, 32'h7, 0, "R8");
    op(5'h10, 0, 0, 1, "R8");
    op(5'h0C, 1, 32'h5, 0, "R8");
    op(5'h10, 0, 0, 1, "R8");
    // R9 acknowledge
    op(5'h18, 0, 0, 1, "R9");
    op(5'h14, 0, 0, 1, "R9");
    // R10 wrap
    op(5'h08, 1, 32'd10, 0, "R10");
    op(5'h04, 1, 32'd12, 0, "R10");
    op(5'h0C, 1, 32'hD, 0, "R10");
    idleRead(12 * P, 5'h00, "R10");
    // R4 32-bit rollover
    op(5'h0C, 1, 32'h4, 0, "R4");
    op(5'h08, 1, 32'hFFFF_FFFE, 0, "R4");
    idleRead(4 * P, 5'h00, "R4");
    // R7 same-cycle set beats acknowledge: random mix covers it
    for (int n = 0; n < 6000; n++) begin
      int sel;
      logic [4:0] ra;
      sel = int'($urandom % 10);
      ra = 5'(($urandom % 8) * 4);
      case (sel)
        0, 1, 2: op(ra, 0, 0, 1, tagFor(ra));
        3: op(5'h04, 1, mCount + ($urandom % 4), 0, "R6");
        4: op(5'h08, 1, ($urandom % 3 == 0) ? 32'hFFFF_FFFF - ($urandom % 3) : $urandom % 16, 0, "R3");
        5: op(5'h0C, 1, ($urandom % 5 == 0) ? $urandom % 16 : ($urandom % 16) | 4, 0, "R2");
        6, 7: op(5'h18, 0, 0, 1, "R9");
        8: op(5'h14, 0, 0, 1, "R7");
        default: op(ra, 1, $urandom, 1, tagFor(ra));
      endcase
    end
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule